// File: doc/BRIEF.md
# Daisy-Chain Readout Token Controller

This block sits in each readout chip of a daisy chain whose members share a single data line. The acquisition side starts a readout pass by sending a token pulse into the first chip. A chip that takes the token with stored data drives the shared line and asks its local memory serializer to stream. When the serializer reports completion, the chip releases the line and sends a one-cycle token pulse to the next chip. A chip with no stored events passes the token after one cycle. A chip marked faulty by its bypass configuration bit forwards the token combinationally and never drives the line.

Chip order in the chain sets the order of access to the line. The token leaving the last chip returns to the acquisition side and marks the end of the pass. A token that reaches a chip already reading out is a protocol fault. The chip ignores it apart from raising a sticky error flag.

Top module: `rdchain_node`

## Requirements
- R1: After a synchronous active-low reset, `bus_en`, `ser_req`, `tok_out` and `tok_err` are all 0.
- R2: A token pulse that arrives while `mem_empty` is 0 and `bypass_cfg` is 0 raises `bus_en` and `ser_req` in the next cycle. Both then stay high until `ser_done` is sampled high.
- R3: When `ser_done` is sampled high during a readout, the next cycle has `tok_out` = 1 for exactly one cycle, with `bus_en` and `ser_req` at 0 in that same cycle.
- R4: A token pulse that arrives while `mem_empty` is 1 (not bypassed) gives a one-cycle `tok_out` pulse in the next cycle, and `bus_en` never rises.
- R5: While `bypass_cfg` is 1, `tok_out` equals `tok_in` in the same cycle, and `bus_en` and `ser_req` stay 0.
- R6: A token pulse that arrives during a readout sets `tok_err` in the next cycle, and it stays set until reset. The readout continues unchanged and gives only the one `tok_out` pulse of R3.
- R7: `ser_done` is ignored when no readout is in progress. It produces no `tok_out`, no `bus_en` and no error.
- R8: In a chain of nodes, at most one `bus_en` is high in any cycle. Enables occur in chain order. Each reading node holds `bus_en` for as many cycles as its serializer streams. The token leaves the last node after the sum of per-node delays: 0 for bypassed nodes, 1 for empty nodes, and 1 plus the stream length for reading nodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_in | input | 1 | Token pulse from the previous chip or the acquisition side |
| bypass_cfg | input | 1 | Slow-control skip bit: forward the token, never drive the line |
| mem_empty | input | 1 | Local memory holds no events |
| ser_done | input | 1 | Serializer has sent its last bit |
| ser_req | output | 1 | Request to the local serializer to stream |
| bus_en | output | 1 | Output enable onto the shared data line |
| tok_out | output | 1 | Token pulse to the next chip |
| tok_err | output | 1 | Sticky flag: token received while reading out |

## Verification
The assertions take `tok_in` to be a single-cycle pulse and take `bypass_cfg` and `mem_empty` as quasi-static. The stimulus changes `bypass_cfg` and `mem_empty` only while the node is idle. The serializer models raise `ser_done` only in the last cycle of a request, except in the one directed case that checks that a stray completion is ignored. The chain sweep covers every combination of reading, empty and bypassed over four nodes. It computes the return time and the per-node enable counts from the stream lengths.

// File: rtl/rdchain_pkg.sv
// Shared types for the readout token chain.
// Assumes: nothing beyond a two-state node controller.
package rdchain_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } rd_state_e;
endpackage

// File: rtl/rdchain_seq.sv
// Token sequencer of one node: accepts a token, runs one readout or passes
// the token on at once when the memory is empty, and emits a registered token
// pulse one cycle after completion.
// Assumes: tok_acc is already masked by bypass; mem_empty is steady at token arrival.
module rdchain_seq
    import rdchain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tok_acc,
    input  logic bypass,
    input  logic mem_empty,
    input  logic ser_done,
    output logic reading,
    output logic tok_q,
    output logic dup_tok
);
    rd_state_e state_q;

    // State and token pulse register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tok_q   <= 1'b0;
        end else begin
            tok_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (tok_acc) begin
                        if (mem_empty) tok_q   <= 1'b1;
                        else           state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (bypass) begin
                        state_q <= ST_IDLE;
                    end else if (ser_done) begin
                        state_q <= ST_IDLE;
                        tok_q   <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded readout phase and duplicate-token detection.
    always_comb begin
        reading = (state_q == ST_READ);
        dup_tok = reading && tok_acc;
    end

    a_r2_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && !ser_done && !bypass) |=> reading);
    a_r3_pass_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && ser_done && !bypass) |=> (tok_q && !reading));
    a_r4_empty_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!reading && tok_acc && mem_empty) |=> (tok_q && !reading));
    a_r7_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!reading && ser_done && !tok_acc) |=> (!reading && !tok_q));
endmodule

// File: rtl/rdchain_errflag.sv
// Sticky protocol error flag, set by a duplicate token, cleared only by reset.
// Assumes: dup_tok is a registered-logic decode that is valid at the clock edge.
module rdchain_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic dup_tok,
    output logic err_q
);
    // Capture and hold any duplicate-token event.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | dup_tok;
    end

    a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        dup_tok |=> err_q);
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/rdchain_node.sv
// Per-chip token controller for a shared-line readout chain. A bypassed node
// forwards the token combinationally; otherwise the sequencer owns the line.
// Assumes: tok_in is a one-cycle pulse; bypass_cfg changes only while idle.
module rdchain_node (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_in,
    input  logic bypass_cfg,
    input  logic mem_empty,
    input  logic ser_done,
    output logic ser_req,
    output logic bus_en,
    output logic tok_out,
    output logic tok_err
);
    logic tok_acc;
    logic reading;
    logic tok_q;
    logic dup_tok;

    // Token qualification and output selection.
    always_comb begin
        tok_acc = tok_in && !bypass_cfg;
        tok_out = bypass_cfg ? tok_in : tok_q;
        bus_en  = reading;
        ser_req = reading;
    end

    rdchain_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_acc   (tok_acc),
        .bypass    (bypass_cfg),
        .mem_empty (mem_empty),
        .ser_done  (ser_done),
        .reading   (reading),
        .tok_q     (tok_q),
        .dup_tok   (dup_tok)
    );

    rdchain_errflag u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .dup_tok (dup_tok),
        .err_q   (tok_err)
    );

    a_r5_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_cfg |=> !bus_en);
    a_r3_no_drive_with_token: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_out && !bypass_cfg) |-> !bus_en);
endmodule

// File: tb/rdchain_node_test.sv
module rdchain_node_test;
    localparam int K = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Standalone node
    logic u_tok_in = 1'b0, u_byp = 1'b0, u_empty = 1'b0, u_done = 1'b0;
    logic u_req, u_en, u_tok_out, u_err;

    rdchain_node uut (
        .clk(clk), .rst_n(rst_n), .tok_in(u_tok_in), .bypass_cfg(u_byp),
        .mem_empty(u_empty), .ser_done(u_done), .ser_req(u_req),
        .bus_en(u_en), .tok_out(u_tok_out), .tok_err(u_err)
    );

    // Chain of K nodes
    logic          chain_in = 1'b0;
    logic [K-1:0]  r_byp = '0, r_empty = '0;
    logic [K:0]    r_tok;
    logic [K-1:0]  r_req, r_en, r_done, r_err;
    logic [3:0]    r_cnt [K];

    assign r_tok[0] = chain_in;

    for (genvar k = 0; k < K; k++) begin : g_ring
        rdchain_node u_node (
            .clk(clk), .rst_n(rst_n), .tok_in(r_tok[k]), .bypass_cfg(r_byp[k]),
            .mem_empty(r_empty[k]), .ser_done(r_done[k]), .ser_req(r_req[k]),
            .bus_en(r_en[k]), .tok_out(r_tok[k+1]), .tok_err(r_err[k])
        );
        // Serializer model: streams 2+k cycles, done in the last one.
        always_ff @(posedge clk) begin
            if (!r_req[k]) r_cnt[k] <= '0;
            else           r_cnt[k] <= r_cnt[k] + 4'd1;
        end
        assign r_done[k] = r_req[k] && (r_cnt[k] == 4'(k + 1));
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_chain(input int cfg);
        int d, ret, pulses, overl, order_bad, last_idx, s;
        int en_cnt [K];
        int exp_en [K];
        int c;
        c = cfg;
        d = 0;
        for (int k = 0; k < K; k++) begin
            r_byp[k]   = ((c % 3) == 2);
            r_empty[k] = ((c % 3) == 1);
            exp_en[k]  = ((c % 3) == 0) ? (2 + k) : 0;
            d += ((c % 3) == 2) ? 0 : (((c % 3) == 1) ? 1 : (3 + k));
            c = c / 3;
            en_cnt[k] = 0;
        end
        step(); step();
        ret = -1; pulses = 0; overl = 0; order_bad = 0; last_idx = -1;
        chain_in = 1'b1;
        for (s = 0; s < 40; s++) begin
            #1;
            if ($countones(r_en) > 1) overl++;
            for (int k = 0; k < K; k++) begin
                if (r_en[k]) begin
                    en_cnt[k]++;
                    if (k < last_idx) order_bad++;
                    last_idx = k;
                end
            end
            if (r_tok[K]) begin
                pulses++;
                if (ret < 0) ret = s;
            end
            step();
            if (s == 0) chain_in = 1'b0;
        end
        chk(ret == d, "R8 token return time", ret, d);
        chk(pulses == 1, "R8 single returning pulse", pulses, 1);
        chk(overl == 0, "R8 overlapping enables", overl, 0);
        chk(order_bad == 0, "R8 enable order", order_bad, 0);
        for (int k = 0; k < K; k++)
            chk(en_cnt[k] == exp_en[k], "R8 enable cycles per node", en_cnt[k], exp_en[k]);
        chk(r_err == '0, "R8 no error in clean chain", int'(r_err), 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk(!u_en && !u_req && !u_tok_out && !u_err, "R1 reset outputs",
            int'({u_en, u_req, u_tok_out, u_err}), 0);
        rst_n = 1'b1;
        step();

        // R2 / R3 readout with data, several lengths
        for (int len = 1; len <= 5; len++) begin
            u_tok_in = 1'b1; step(); u_tok_in = 1'b0;
            chk(u_en && u_req, "R2 enable after token", int'({u_en, u_req}), 3);
            for (int i = 1; i < len; i++) begin
                step();
                chk(u_en && u_req && !u_tok_out, "R2 enable held", int'({u_en, u_req, u_tok_out}), 6);
            end
            u_done = 1'b1; step(); u_done = 1'b0;
            chk(u_tok_out && !u_en && !u_req, "R3 token after done", int'({u_tok_out, u_en, u_req}), 4);
            step();
            chk(!u_tok_out && !u_en, "R3 single-cycle token", int'({u_tok_out, u_en}), 0);
        end

        // R4 empty memory
        u_empty = 1'b1;
        u_tok_in = 1'b1; step(); u_tok_in = 1'b0;
        chk(u_tok_out && !u_en, "R4 empty pass", int'({u_tok_out, u_en}), 2);
        step();
        chk(!u_tok_out && !u_en, "R4 pulse ends", int'({u_tok_out, u_en}), 0);
        u_empty = 1'b0;

        // R7 stray done while idle
        u_done = 1'b1; step(); u_done = 1'b0;
        chk(!u_tok_out && !u_en && !u_err, "R7 stray done ignored", int'({u_tok_out, u_en, u_err}), 0);
        step();
        chk(!u_tok_out && !u_en, "R7 still idle", int'({u_tok_out, u_en}), 0);

        // R5 bypass pass-through
        u_byp = 1'b1; step();
        u_tok_in = 1'b1; #1;
        chk(u_tok_out == 1'b1, "R5 combinational pass", int'(u_tok_out), 1);
        step(); u_tok_in = 1'b0; #1;
        chk(!u_tok_out && !u_en && !u_req, "R5 no drive when bypassed", int'({u_tok_out, u_en, u_req}), 0);
        step();
        u_byp = 1'b0; step();

        // R6 duplicate token during readout
        u_tok_in = 1'b1; step(); u_tok_in = 1'b0;
        step();
        u_tok_in = 1'b1; step(); u_tok_in = 1'b0;
        chk(u_err && u_en && !u_tok_out, "R6 error set, readout kept", int'({u_err, u_en, u_tok_out}), 6);
        u_done = 1'b1; step(); u_done = 1'b0;
        chk(u_tok_out && !u_en, "R6 single token after done", int'({u_tok_out, u_en}), 2);
        step();
        chk(!u_tok_out && u_err, "R6 no extra token, error sticky", int'({u_tok_out, u_err}), 1);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk(!u_err, "R1 reset clears error", int'(u_err), 0);
        step();

        // R8 exhaustive chain sweep: 3 modes on each of K nodes
        for (int cfg = 0; cfg < 81; cfg++) run_chain(cfg);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule